// File: doc/BRIEF.md
# Serial Register Port with Frame Parity

This block is the configuration port of a multi-channel front-end chip. An external controller sends 16-bit serial frames while chip select is low. Each frame holds, MSB first, a direction flag, a 6-bit register address, eight data bits and an even-parity bit. The block keeps a small register file. It drives the configuration fields onto parallel outputs for the rest of the chip. It also presents a few status inputs as read-only registers.

All serial pins are sampled by the system clock through synchronizers. Frame edges are found there. A write lands in the register file only when chip select returns high after exactly sixteen serial clocks. If parity checking is switched on, a write must also carry correct parity. A frame that fails either test sets a sticky error bit. On a read, the addressed byte and a computed parity bit are shifted out on falling serial clock edges. The output enable for the data pad is raised only during that window.

Top module: `serial_reg_port`

## Requirements
- R1: A frame is 16 bits, MSB first, with data in sampled on rising serial clock edges. Bit 15 is the direction (0 write, 1 read), bits 14..9 are the address, bits 8..1 are the data and bit 0 is parity. A write updates the addressed register only when chip select rises after exactly 16 clocks.
- R2: After reset, addresses 0x09 through 0x10 read 0x10, and every writable register at 0x04..0x08 and 0x11 reads 0x00.
- R3: Writes change only defined bits. The defined bits are: 0x05 bits 1:0, 0x06 bit 0, 0x07 bits 7:0, 0x08 bits 4:0, 0x09..0x11 bits 4:0, and none at 0x04. Undefined bits always read 0.
- R4: While bit 4 of 0x11 (parity check enable) is 0, the parity bit of a write is ignored.
- R5: While parity checking is enabled (as held before the frame), a write whose bit 0 differs from the XOR of bits 14..1 changes nothing. It also sets the error bit, bit 3 of 0x01.
- R6: A frame whose serial clock count is not 16 writes nothing and sets the error bit.
- R7: The error bit stays set through later good frames until reset.
- R8: On a read, the data out line changes on falling edges. It presents D7..D0 and then the XOR of address and data, on clocks 8 through 16. The output enable is high from the falling edge after clock 7 until chip select rises, and low at all other times, including the whole of every write frame.
- R9: Address 0x00 reads 0x61. Writes to 0x00..0x03 or to any address above 0x11 are ignored and do not set the error bit. Reads above 0x11 return 0x00.
- R10: The parallel outputs mirror the registers, as follows.
  - calStart is 0x05 bit 0; calApply is 0x05 bit 1; sleepAll is 0x06 bit 0.
  - chanOff is 0x07, and pga2Code is 0x08 bits 4:3.
  - Channel k's 5-bit fineGain slice (bits 5k+4..5k) is register 0x09+k.
  - hpfSel is 0x11 bits 2:0, hpfOn is bit 3 and parityOn is bit 4.
  - pga1Step is 0x08 bits 2:0, except that any code with bit 2 set gives 4. Readback of 0x08 still shows the stored code.
- R11: Register 0x01 reads bit 7 = 1, bit 4 = vcomFault, bit 3 = error bit, bit 0 = irefFault, other bits 0. Register 0x02 reads calDone in bit 0, and register 0x03 reads calFault.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| csN | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdoOe | output | 1 | Output enable for the data-out pad buffer |
| vcomFault | input | 1 | Reference voltage fault status |
| irefFault | input | 1 | Reference current fault status |
| calDone | input | 1 | Offset calibration finished status |
| calFault | input | 8 | Per-channel calibration range fault |
| calStart | output | 1 | Calibration start request |
| calApply | output | 1 | Calibration result enable |
| sleepAll | output | 1 | Sleep request for all channels |
| chanOff | output | 8 | Per-channel processing off |
| pga1Step | output | 3 | First-stage gain step, 0..4 |
| pga2Code | output | 2 | Second-stage gain code |
| fineGain | output | 40 | Five-bit fine gain per channel |
| hpfSel | output | 3 | High-pass corner select |
| hpfOn | output | 1 | High-pass filter enable |
| parityOn | output | 1 | Write parity check enable |

## Verification
The assertions assume that the serial clock is much slower than the system clock. Each serial level must last longer than the synchronizer depth plus one cycle, so that every edge becomes exactly one strobe. They also assume that data in is stable around each rising serial edge and that chip select moves only while the serial clock is low. The stimulus meets these conditions:
- It holds each serial half period for eight system clocks.
- It changes data in together with the falling serial edge.
- It waits well over two serial periods between frames.

The status inputs change only between frames.

// File: rtl/srp_pkg.sv
`timescale 1ns/1ps
package srp_pkg;
  // One-cycle strobes from the serial control to the register datapath.
  typedef struct packed {
    logic sampleIn;  // rising serial edge inside a frame
    logic loadOut;   // falling edge that starts the read window
    logic shiftOut;  // falling edge that advances the read window
    logic frameEnd;  // chip select released
    logic countOk;   // the frame had exactly the nominal clock count
  } srpStrobe_t;
endpackage

// File: rtl/srp_ctrl.sv
`timescale 1ns/1ps
module srp_ctrl
  import srp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FRAME_BITS  = 16,
  parameter int OUT_BITS    = 9
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sclk,
  input  logic       sdi,
  output srpStrobe_t strobe,
  output logic       sdiSync
);
  localparam int CNT_W   = $clog2(FRAME_BITS + 2);
  localparam int LOAD_AT = FRAME_BITS - OUT_BITS;

  logic [SYNC_STAGES-1:0] csPipe, clkPipe, dinPipe;
  logic csPrev, clkPrev;
  logic csNow, clkNow;
  logic riseEdge, fallEdge;
  logic [CNT_W-1:0] bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPipe  <= '1;
      clkPipe <= '0;
      dinPipe <= '0;
      csPrev  <= 1'b1;
      clkPrev <= 1'b0;
    end else begin
      csPipe  <= {csPipe[SYNC_STAGES-2:0], csN};
      clkPipe <= {clkPipe[SYNC_STAGES-2:0], sclk};
      dinPipe <= {dinPipe[SYNC_STAGES-2:0], sdi};
      csPrev  <= csPipe[SYNC_STAGES-1];
      clkPrev <= clkPipe[SYNC_STAGES-1];
    end
  end

  assign csNow    = csPipe[SYNC_STAGES-1];
  assign clkNow   = clkPipe[SYNC_STAGES-1];
  assign sdiSync  = dinPipe[SYNC_STAGES-1];
  assign riseEdge = clkNow & ~clkPrev;
  assign fallEdge = ~clkNow & clkPrev;

  // Clock counter: held at zero while deselected, saturates at its top.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        bitCnt <= '0;
    else if (csNow)                   bitCnt <= '0;
    else if (riseEdge && bitCnt != '1) bitCnt <= bitCnt + 1'b1;
  end

  always_comb begin
    strobe.sampleIn = riseEdge & ~csNow;
    strobe.loadOut  = fallEdge & ~csNow & (bitCnt == CNT_W'(LOAD_AT));
    strobe.shiftOut = fallEdge & ~csNow & (bitCnt > CNT_W'(LOAD_AT)) &
                      (bitCnt < CNT_W'(FRAME_BITS));
    strobe.frameEnd = csNow & ~csPrev;
    strobe.countOk  = (bitCnt == CNT_W'(FRAME_BITS));
  end

  // R1: at most one frame event per system cycle
  p_one_strobe_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.sampleIn, strobe.loadOut, strobe.shiftOut, strobe.frameEnd}));

  // R6: the clock count starts over after every frame
  p_cnt_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.frameEnd |=> bitCnt == '0);
endmodule

// File: rtl/srp_regs.sv
`timescale 1ns/1ps
module srp_regs
  import srp_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int FG_BITS    = 5,
  parameter int ADDR_BITS  = 6,
  parameter int DATA_BITS  = 8,
  parameter int FRAME_BITS = 16,
  parameter logic [7:0] ID_VALUE = 8'h61
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  srpStrobe_t                 strobe,
  input  logic                       sdiSync,
  input  logic                       vcomFault,
  input  logic                       irefFault,
  input  logic                       calDone,
  input  logic [NUM_CH-1:0]          calFault,
  output logic                       sdo,
  output logic                       sdoOe,
  output logic                       calStart,
  output logic                       calApply,
  output logic                       sleepAll,
  output logic [NUM_CH-1:0]          chanOff,
  output logic [2:0]                 pga1Step,
  output logic [1:0]                 pga2Code,
  output logic [NUM_CH*FG_BITS-1:0]  fineGain,
  output logic [2:0]                 hpfSel,
  output logic                       hpfOn,
  output logic                       parityOn
);
  localparam int A_ID     = 0;
  localparam int A_FAULT  = 1;
  localparam int A_CAL    = 2;
  localparam int A_CALERR = 3;
  localparam int A_CALCTL = 5;
  localparam int A_SLEEP  = 6;
  localparam int A_CHOFF  = 7;
  localparam int A_GAIN   = 8;
  localparam int FG_BASE  = 9;
  localparam int A_HPF    = FG_BASE + NUM_CH;
  localparam int NUM_REGS = A_HPF + 1;
  localparam int IDX_W    = $clog2(NUM_REGS);
  localparam int RW_POS   = FRAME_BITS - 1;
  localparam int ADDR_LSB = 1 + DATA_BITS;

  typedef logic [DATA_BITS-1:0] byte_t;

  function automatic byte_t maskOf(int a);
    if (a == A_CALCTL)                              return byte_t'(8'h03);
    else if (a == A_SLEEP)                          return byte_t'(8'h01);
    else if (a == A_CHOFF)                          return byte_t'(8'hFF);
    else if (a == A_GAIN)                           return byte_t'(8'h1F);
    else if (a >= FG_BASE && a < FG_BASE + NUM_CH)  return byte_t'((1 << FG_BITS) - 1);
    else if (a == A_HPF)                            return byte_t'(8'h1F);
    else                                            return '0;
  endfunction

  function automatic byte_t resetOf(int a);
    if (a >= FG_BASE && a < FG_BASE + NUM_CH) return byte_t'(1 << (FG_BITS - 1));
    else                                      return '0;
  endfunction

  logic [FRAME_BITS-1:0]            inSr;
  logic [NUM_REGS-1:0][DATA_BITS-1:0] regQ;
  logic [DATA_BITS:0]               outSr;
  logic                             spiErr;
  logic                             fRw, parityGood, wrOk, errSet;
  logic [ADDR_BITS-1:0]             fAddr, rdAddr;
  byte_t                            fData, rdData;

  // Shift register for the incoming frame.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                inSr <= '0;
    else if (strobe.sampleIn) inSr <= {inSr[FRAME_BITS-2:0], sdiSync};
  end

  assign fRw        = inSr[RW_POS];
  assign fAddr      = inSr[ADDR_LSB +: ADDR_BITS];
  assign fData      = inSr[1 +: DATA_BITS];
  assign parityGood = ~(^inSr[FRAME_BITS-2:0]);
  assign wrOk   = strobe.frameEnd & strobe.countOk & ~fRw & (~parityOn | parityGood);
  assign errSet = strobe.frameEnd &
                  (~strobe.countOk | (~fRw & parityOn & ~parityGood));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regQ[i] <= resetOf(i);
    end else if (wrOk) begin
      for (int i = 0; i < NUM_REGS; i++)
        if (fAddr == ADDR_BITS'(i))
          regQ[i] <= (regQ[i] & ~maskOf(i)) | (fData & maskOf(i));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       spiErr <= 1'b0;
    else if (errSet) spiErr <= 1'b1;
  end

  // Read source: address is complete after the seventh sampled bit.
  assign rdAddr = inSr[ADDR_BITS-1:0];
  always_comb begin
    if (rdAddr == ADDR_BITS'(A_ID))
      rdData = ID_VALUE;
    else if (rdAddr == ADDR_BITS'(A_FAULT))
      rdData = byte_t'({1'b1, 2'b00, vcomFault, spiErr, 2'b00, irefFault});
    else if (rdAddr == ADDR_BITS'(A_CAL))
      rdData = byte_t'(calDone);
    else if (rdAddr == ADDR_BITS'(A_CALERR))
      rdData = byte_t'(calFault);
    else if (rdAddr < ADDR_BITS'(NUM_REGS))
      rdData = regQ[rdAddr[IDX_W-1:0]];
    else
      rdData = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outSr <= '0;
      sdoOe <= 1'b0;
    end else if (strobe.loadOut) begin
      outSr <= {rdData, ^{rdAddr, rdData}};
      sdoOe <= inSr[ADDR_BITS];
    end else if (strobe.shiftOut) begin
      outSr <= {outSr[DATA_BITS-1:0], 1'b0};
    end else if (strobe.frameEnd) begin
      sdoOe <= 1'b0;
    end
  end
  assign sdo = outSr[DATA_BITS];

  // Parallel configuration outputs.
  assign calStart = regQ[A_CALCTL][0];
  assign calApply = regQ[A_CALCTL][1];
  assign sleepAll = regQ[A_SLEEP][0];
  assign chanOff  = regQ[A_CHOFF][NUM_CH-1:0];
  assign pga1Step = regQ[A_GAIN][2] ? 3'd4 : {1'b0, regQ[A_GAIN][1:0]};
  assign pga2Code = regQ[A_GAIN][4:3];
  assign hpfSel   = regQ[A_HPF][2:0];
  assign hpfOn    = regQ[A_HPF][3];
  assign parityOn = regQ[A_HPF][4];

  for (genvar k = 0; k < NUM_CH; k++) begin : g_fine
    assign fineGain[k*FG_BITS +: FG_BITS] = regQ[FG_BASE + k][FG_BITS-1:0];
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_spare
    localparam byte_t KEEP = maskOf(i);
    // R3: undefined bits never become set
    p_spare_bits_r3: assert property (@(posedge clk) disable iff (!rstN)
      (regQ[i] & ~KEEP) == '0);
  end

  // R5: a checked write with bad parity leaves the file alone and flags it
  p_par_reject_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.frameEnd && strobe.countOk && !inSr[RW_POS] && parityOn &&
    (^inSr[FRAME_BITS-2:0]) |=> $stable(regQ) && spiErr);

  // R6: wrong clock count writes nothing and flags it
  p_count_reject_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.frameEnd && !strobe.countOk |=> $stable(regQ) && spiErr);

  // R7: the error bit is sticky
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    spiErr |=> spiErr);

  // R8: pad released after the frame, and data only moves on its strobes
  p_oe_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.frameEnd |=> !sdoOe);
  p_sdo_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    sdoOe && !strobe.loadOut && !strobe.shiftOut |=> $stable(sdo));
endmodule

// File: rtl/serial_reg_port.sv
`timescale 1ns/1ps
module serial_reg_port
  import srp_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int FG_BITS     = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      csN,
  input  logic                      sclk,
  input  logic                      sdi,
  output logic                      sdo,
  output logic                      sdoOe,
  input  logic                      vcomFault,
  input  logic                      irefFault,
  input  logic                      calDone,
  input  logic [NUM_CH-1:0]         calFault,
  output logic                      calStart,
  output logic                      calApply,
  output logic                      sleepAll,
  output logic [NUM_CH-1:0]         chanOff,
  output logic [2:0]                pga1Step,
  output logic [1:0]                pga2Code,
  output logic [NUM_CH*FG_BITS-1:0] fineGain,
  output logic [2:0]                hpfSel,
  output logic                      hpfOn,
  output logic                      parityOn
);
  localparam int ADDR_BITS  = 6;
  localparam int DATA_BITS  = 8;
  localparam int FRAME_BITS = 2 + ADDR_BITS + DATA_BITS;

  srpStrobe_t strobe;
  logic       sdiSync;

  srp_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .FRAME_BITS (FRAME_BITS),
    .OUT_BITS   (DATA_BITS + 1)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .csN    (csN),
    .sclk   (sclk),
    .sdi    (sdi),
    .strobe (strobe),
    .sdiSync(sdiSync)
  );

  srp_regs #(
    .NUM_CH    (NUM_CH),
    .FG_BITS   (FG_BITS),
    .ADDR_BITS (ADDR_BITS),
    .DATA_BITS (DATA_BITS),
    .FRAME_BITS(FRAME_BITS)
  ) u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .sdiSync  (sdiSync),
    .vcomFault(vcomFault),
    .irefFault(irefFault),
    .calDone  (calDone),
    .calFault (calFault),
    .sdo      (sdo),
    .sdoOe    (sdoOe),
    .calStart (calStart),
    .calApply (calApply),
    .sleepAll (sleepAll),
    .chanOff  (chanOff),
    .pga1Step (pga1Step),
    .pga2Code (pga2Code),
    .fineGain (fineGain),
    .hpfSel   (hpfSel),
    .hpfOn    (hpfOn),
    .parityOn (parityOn)
  );
endmodule

// File: tb/serial_reg_port_bench.sv
`timescale 1ns/1ps
module serial_reg_port_bench;
  localparam int HALF = 8;
  localparam int NV   = 23;

  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic vcomFault = 1'b0, irefFault = 1'b0, calDone = 1'b1;
  logic [7:0]  calFault = 8'h00;
  logic sdo, sdoOe, calStart, calApply, sleepAll, hpfOn, parityOn;
  logic [7:0]  chanOff;
  logic [2:0]  pga1Step, hpfSel;
  logic [1:0]  pga2Code;
  logic [39:0] fineGain;

  int total = 0, bad = 0;
  logic [7:0] rdByte;
  logic       rdPar, oeOk;

  always #4 clk = ~clk;

  serial_reg_port u_serial_reg_port (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdoOe(sdoOe), .vcomFault(vcomFault), .irefFault(irefFault),
    .calDone(calDone), .calFault(calFault), .calStart(calStart),
    .calApply(calApply), .sleepAll(sleepAll), .chanOff(chanOff),
    .pga1Step(pga1Step), .pga2Code(pga2Code), .fineGain(fineGain),
    .hpfSel(hpfSel), .hpfOn(hpfOn), .parityOn(parityOn));

  // {req[3:0], rw, addr[5:0], data[7:0], expected[7:0]}
  localparam logic [26:0] VEC [NV] = '{
    {4'd9,  1'b1, 6'h00, 8'h00, 8'h61},  // R9 identity byte
    {4'd11, 1'b1, 6'h01, 8'h00, 8'h80},  // R11 fault register idle
    {4'd11, 1'b1, 6'h02, 8'h00, 8'h01},  // R11 calDone high
    {4'd2,  1'b1, 6'h09, 8'h00, 8'h10},  // R2 first fine gain
    {4'd2,  1'b1, 6'h10, 8'h00, 8'h10},  // R2 last fine gain
    {4'd2,  1'b1, 6'h11, 8'h00, 8'h00},  // R2 filter register
    {4'd1,  1'b0, 6'h07, 8'hA5, 8'h00},  // R1 write
    {4'd1,  1'b1, 6'h07, 8'h00, 8'hA5},  // R1 readback
    {4'd3,  1'b0, 6'h08, 8'hFF, 8'h00},  // R3
    {4'd3,  1'b1, 6'h08, 8'h00, 8'h1F},  // R3 bits 7:5 dropped
    {4'd3,  1'b0, 6'h05, 8'hFF, 8'h00},  // R3
    {4'd3,  1'b1, 6'h05, 8'h00, 8'h03},  // R3
    {4'd3,  1'b0, 6'h06, 8'hFE, 8'h00},  // R3
    {4'd3,  1'b1, 6'h06, 8'h00, 8'h00},  // R3
    {4'd1,  1'b0, 6'h0C, 8'h07, 8'h00},  // R1 fine gain channel 3
    {4'd1,  1'b1, 6'h0C, 8'h00, 8'h07},  // R1
    {4'd9,  1'b0, 6'h00, 8'h12, 8'h00},  // R9 write to read-only
    {4'd9,  1'b1, 6'h00, 8'h00, 8'h61},  // R9 unchanged
    {4'd9,  1'b0, 6'h20, 8'h55, 8'h00},  // R9 write to unmapped
    {4'd9,  1'b1, 6'h20, 8'h00, 8'h00},  // R9 unmapped reads zero
    {4'd9,  1'b1, 6'h01, 8'h00, 8'h80},  // R9 no error flagged
    {4'd3,  1'b0, 6'h04, 8'hFF, 8'h00},  // R3 spare register
    {4'd3,  1'b1, 6'h04, 8'h00, 8'h00}   // R3
  };

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);
  endtask

  task automatic frame(input logic rw, input logic [5:0] a, input logic [7:0] d,
                       input bit flipPar, input int nClk);
    logic [15:0] f;
    f = {rw, a, d, (^{a, d}) ^ flipPar};
    rdByte = 8'h00;
    rdPar  = 1'b0;
    oeOk   = 1'b1;
    csN = 1'b0;
    waitClk(HALF);
    for (int i = 0; i < nClk; i++) begin
      sdi = (i < 16) ? f[15-i] : 1'b0;
      waitClk(HALF);
      if (rw && i >= 7 && i < 16) begin
        if (!sdoOe) oeOk = 1'b0;
        if (i < 15) rdByte = {rdByte[6:0], sdo};
        else        rdPar  = sdo;
      end else if (sdoOe) begin
        oeOk = 1'b0;
      end
      sclk = 1'b1;
      waitClk(HALF);
      sclk = 1'b0;
    end
    waitClk(HALF);
    csN = 1'b1;
    sdi = 1'b0;
    waitClk(4 * HALF);
    if (sdoOe) oeOk = 1'b0;
  endtask

  task automatic writeReg(input logic [5:0] a, input logic [7:0] d, input bit flipPar);
    frame(1'b0, a, d, flipPar, 16);
    check(oeOk, "R8", "pad enable during write", 0, 0);
  endtask

  task automatic readReg(input logic [5:0] a, input logic [7:0] exp, input string req);
    frame(1'b1, a, 8'h00, 1'b0, 16);
    check(rdByte == exp, req, $sformatf("read addr 0x%0h", a), rdByte, exp);
    check(rdPar == ^{a, exp}, "R8", "read parity bit", rdPar, ^{a, exp});
    check(oeOk, "R8", "pad enable window on read", 0, 0);
  endtask

  initial begin
    waitClk(150000);
    bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    doReset();
    // R2 reset state at the ports
    check(sdoOe == 1'b0, "R8", "enable after reset", sdoOe, 0);
    check(fineGain == {8{5'h10}}, "R2", "fine gain defaults", fineGain, {8{5'h10}});
    check(chanOff == 8'h00 && pga1Step == 3'd0 && parityOn == 1'b0 && hpfOn == 1'b0,
          "R2", "config defaults", {chanOff, pga1Step, parityOn, hpfOn}, 0);

    for (int k = 0; k < NV; k++) begin
      if (VEC[k][22]) readReg(VEC[k][21:16], VEC[k][7:0], $sformatf("R%0d", VEC[k][26:23]));
      else            writeReg(VEC[k][21:16], VEC[k][15:8], 1'b0);
    end

    // R10 parallel outputs after the table
    check(chanOff == 8'hA5, "R10", "chanOff", chanOff, 8'hA5);
    check(pga1Step == 3'd4, "R10", "pga1Step from code 7", pga1Step, 4);
    check(pga2Code == 2'd3, "R10", "pga2Code", pga2Code, 3);
    check(fineGain[15 +: 5] == 5'h07, "R10", "fine gain channel 3", fineGain[15 +: 5], 7);
    check(calStart && calApply && !sleepAll, "R10", "cal and sleep bits",
          {calStart, calApply, sleepAll}, 3'b110);
    writeReg(6'h08, 8'h03, 1'b0);
    check(pga1Step == 3'd3, "R10", "pga1Step code 3", pga1Step, 3);
    writeReg(6'h08, 8'h04, 1'b0);
    check(pga1Step == 3'd4, "R10", "pga1Step code 4", pga1Step, 4);
    readReg(6'h08, 8'h04, "R10");

    // R4 parity ignored while checking is off
    writeReg(6'h0A, 8'h0B, 1'b1);
    readReg(6'h0A, 8'h0B, "R4");
    readReg(6'h01, 8'h80, "R4");

    // R5 parity checking on
    writeReg(6'h11, 8'h1D, 1'b0);
    check(parityOn && hpfOn && hpfSel == 3'd5, "R10", "filter register fields",
          {parityOn, hpfOn, hpfSel}, 5'b11101);
    writeReg(6'h0A, 8'h03, 1'b1);
    readReg(6'h0A, 8'h0B, "R5");
    readReg(6'h01, 8'h88, "R5");
    writeReg(6'h0A, 8'h03, 1'b0);
    readReg(6'h0A, 8'h03, "R5");
    readReg(6'h01, 8'h88, "R7");

    // R11 status inputs
    vcomFault = 1'b1; irefFault = 1'b1; calDone = 1'b0; calFault = 8'h5A;
    waitClk(4);
    readReg(6'h01, 8'h99, "R11");
    readReg(6'h02, 8'h00, "R11");
    readReg(6'h03, 8'h5A, "R11");
    vcomFault = 1'b0; irefFault = 1'b0; calDone = 1'b1; calFault = 8'h00;

    // R6 short frame
    doReset();
    readReg(6'h01, 8'h80, "R7");
    frame(1'b0, 6'h07, 8'h3C, 1'b0, 15);
    readReg(6'h07, 8'h00, "R6");
    readReg(6'h01, 8'h88, "R6");

    // R6 long frame
    doReset();
    frame(1'b0, 6'h07, 8'h3C, 1'b0, 17);
    check(chanOff == 8'h00, "R6", "chanOff after long frame", chanOff, 0);
    readReg(6'h07, 8'h00, "R6");
    readReg(6'h01, 8'h88, "R6");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule